// File: doc/BRIEF.md
# Transmit Clock Loss and All-Ones Controller

This block controls the digital side of a T1 line transmitter. It runs on a free-running reference clock and watches two incoming clocks: the transmit clock and a master clock. It judges whether each one is alive by timing the gap since its last rising edge. Bit timing comes from the transmit clock when it is present. Otherwise the master clock is used, and failing both, a bit tick divided down from the reference.

In normal operation, the positive and negative rail enables follow the data inputs on each transmit clock edge. An all-ones request replaces the data with continuous marks. The marks alternate between the two rails, and the request is suppressed while remote loopback is active. The driver enable drops in two cases: when software asks for high impedance, or when the transmit clock has been silent for 175 bit periods and all-ones is not running. After any change to a transmit control bit, a settling flag stays high for a fixed number of bit periods.

Top module: `tx_guard_ctrl`

## Requirements
- R1: With all-ones inactive, `drv_en_o` goes low once no transmit clock rising edge has been seen for LOSS_BITS*REF_PER_BIT reference cycles (700 by default). It does not go low before that.
- R2: After a transmit clock loss, the first returning transmit clock edge restores `drv_en_o` within 8 reference cycles, and the loss count starts again.
- R3: While `hiz_req_i` is 1, `drv_en_o` is 0 from the next cycle on, whatever the clock and all-ones state.
- R4: `src_o` reports the bit timing source: 0 for the transmit clock when present, otherwise 1 for the master clock when present, otherwise 2 for the reference divider. Master clock presence uses the same edge timeout as the transmit clock.
- R5: While all-ones is effective, every bit tick of the selected source emits one mark. Exactly one of `pos_o`/`neg_o` is high, and the rails alternate on each tick. `data_pos_i`/`data_neg_i` are ignored.
- R6: While all-ones is effective, `drv_en_o` stays high even when the transmit clock is lost.
- R7: With all-ones not effective, `pos_o`/`neg_o` take `data_pos_i`/`data_neg_i` on each rising edge of a present transmit clock.
- R8: While `rloop_i` is 1, `aos_req_i` is ignored and data passes as in R7.
- R9: A change in `ctrl_i` or in effective all-ones sets `settling_o` on the next cycle. The flag clears after SETTLE_BITS bit ticks (22).
- R10: Toggling `aos_req_i` while `rloop_i` is 1 does not start a settling period.
- R11: During reset, `pos_o`, `neg_o`, `drv_en_o` and `settling_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tclk_i | input | 1 | Transmit clock, sampled |
| mclk_i | input | 1 | Master clock, sampled |
| data_pos_i | input | 1 | Positive rail data |
| data_neg_i | input | 1 | Negative rail data |
| aos_req_i | input | 1 | All-ones request |
| rloop_i | input | 1 | Remote loopback active |
| hiz_req_i | input | 1 | Software high-impedance request |
| ctrl_i | input | CTRL_W | Line length, build-out and local loopback bits |
| pos_o | output | 1 | Positive rail pulse enable |
| neg_o | output | 1 | Negative rail pulse enable |
| drv_en_o | output | 1 | Line driver enable (0 = high impedance) |
| settling_o | output | 1 | Transmitter settling flag |
| src_o | output | 2 | Selected timing source |

## Verification
The bench probes the loss timeout from both sides: at 690 cycles after the clock stops, and again past 700. An off-by-one or wrongly scaled counter would tri-state early or never. It steps all-ones through all three timing sources and counts rail toggles against each source's rate. A wrong priority shows up as the wrong mark rate or the wrong `src_o`, and a polarity bug shows up as both rails high. It toggles the request under remote loopback and checks that data still passes and that no settling period starts. It also times the settling flag against 22 transmit clock ticks, so a counter driven by the reference clock or of the wrong length fails.

// File: rtl/tx_guard_pkg.sv
package tx_guard_pkg;
  typedef enum logic [1:0] {
    SRC_TCLK = 2'd0,
    SRC_MCLK = 2'd1,
    SRC_REF  = 2'd2
  } clk_src_e;
endpackage

// File: rtl/tx_edge_watch.sv
module tx_edge_watch #(
  parameter int unsigned LIMIT = 700
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o,
  output logic lost_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], sig_i};
  end

  assign edge_o = sync_q[1] & ~sync_q[2];

  // saturating gap counter, cleared by each rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (edge_o)               cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign lost_o = (cnt_q == CW'(LIMIT));

  // R2
  edge_clears_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !lost_o);
endmodule

// File: rtl/tx_settle.sv
module tx_settle #(
  parameter int unsigned W    = 7,
  parameter int unsigned BITS = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ctrl_i,
  input  logic         tick_i,
  output logic         busy_o
);
  localparam int unsigned CW = $clog2(BITS + 1);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] cnt_q;
  logic          chg;

  assign chg = (ctrl_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= ctrl_i;
      if (chg)                      cnt_q <= CW'(BITS);
      else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

  // R9
  change_starts_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> busy_o);
endmodule

// File: rtl/tx_guard_ctrl.sv
module tx_guard_ctrl
  import tx_guard_pkg::*;
#(
  parameter int unsigned REF_PER_BIT = 4,
  parameter int unsigned LOSS_BITS   = 175,
  parameter int unsigned SETTLE_BITS = 22,
  parameter int unsigned CTRL_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tclk_i,
  input  logic              mclk_i,
  input  logic              data_pos_i,
  input  logic              data_neg_i,
  input  logic              aos_req_i,
  input  logic              rloop_i,
  input  logic              hiz_req_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              pos_o,
  output logic              neg_o,
  output logic              drv_en_o,
  output logic              settling_o,
  output logic [1:0]        src_o
);
  localparam int unsigned LOSS_CYC = LOSS_BITS * REF_PER_BIT;
  localparam int unsigned DW       = $clog2(REF_PER_BIT + 1);

  logic [1:0] clk_vec, edge_v, lost_v;
  assign clk_vec = {mclk_i, tclk_i};

  for (genvar g = 0; g < 2; g++) begin : g_watch
    tx_edge_watch #(.LIMIT(LOSS_CYC)) u_watch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (clk_vec[g]),
      .edge_o (edge_v[g]),
      .lost_o (lost_v[g])
    );
  end

  logic tclk_ok, mclk_ok;
  assign tclk_ok = ~lost_v[0];
  assign mclk_ok = ~lost_v[1];

  // reference bit divider
  logic [DW-1:0] div_q;
  logic          ref_tick;
  assign ref_tick = (div_q == DW'(REF_PER_BIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (ref_tick) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  clk_src_e src;
  logic     tick;
  always_comb begin
    if (tclk_ok) begin
      src  = SRC_TCLK;
      tick = edge_v[0];
    end else if (mclk_ok) begin
      src  = SRC_MCLK;
      tick = edge_v[1];
    end else begin
      src  = SRC_REF;
      tick = ref_tick;
    end
  end
  assign src_o = src;

  logic aos_eff, tclk_tick;
  assign aos_eff   = aos_req_i & ~rloop_i;
  assign tclk_tick = edge_v[0] & tclk_ok;

  logic phase_q, pos_q, neg_q, drv_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      pos_q   <= 1'b0;
      neg_q   <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      drv_q <= ~hiz_req_i & (aos_eff | tclk_ok);
      if (aos_eff) begin
        if (tick) begin
          pos_q   <= ~phase_q;
          neg_q   <= phase_q;
          phase_q <= ~phase_q;
        end
      end else if (tclk_tick) begin
        pos_q <= data_pos_i;
        neg_q <= data_neg_i;
      end
    end
  end

  assign pos_o    = pos_q;
  assign neg_o    = neg_q;
  assign drv_en_o = drv_q;

  tx_settle #(.W(CTRL_W + 1), .BITS(SETTLE_BITS)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i ({aos_eff, ctrl_i}),
    .tick_i (tick),
    .busy_o (settling_o)
  );

  // R3
  hiz_forces_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_req_i |=> !drv_en_o);
  // R5
  aos_one_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aos_eff && tick) |=> (pos_o != neg_o));
  // R8
  rloop_passes_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rloop_i && tclk_tick) |=> (pos_o == $past(data_pos_i) && neg_o == $past(data_neg_i)));
  // R6
  aos_keeps_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aos_eff && !hiz_req_i) |=> drv_en_o);
endmodule

// File: tb/tb_tx_guard_ctrl.sv
module tb_tx_guard_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tclk = 1'b0, mclk = 1'b0;
  logic dpos = 1'b0, dneg = 1'b0, aos = 1'b0, rloop = 1'b0, hiz = 1'b0;
  logic [5:0] ctrl = '0;
  logic pos, neg, drv_en, settling;
  logic [1:0] src;
  logic tclk_run = 1'b0, mclk_run = 1'b0;
  logic [3:0] tc = '0, mc = '0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (tclk_run) tc <= tc + 1'b1;
    if (mclk_run) mc <= mc + 1'b1;
    tclk <= tc[1];
    mclk <= mc[2];
  end

  tx_guard_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk), .mclk_i(mclk),
    .data_pos_i(dpos), .data_neg_i(dneg), .aos_req_i(aos), .rloop_i(rloop),
    .hiz_req_i(hiz), .ctrl_i(ctrl), .pos_o(pos), .neg_o(neg),
    .drv_en_o(drv_en), .settling_o(settling), .src_o(src)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts pos toggles over n cycles; checks one rail high each cycle
  task automatic count_marks(input int n, output int tog, output int bad);
    logic last;
    tog = 0; bad = 0; last = pos;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pos == neg) bad++;
      if (pos != last) tog++;
      last = pos;
    end
  endtask

  task automatic t_reset;
    chk(pos == 0 && neg == 0, "R11 rails", {pos, neg}, 0);
    chk(drv_en == 0, "R11 drv_en", drv_en, 0);
    chk(settling == 0, "R11 settling", settling, 0);
  endtask

  task automatic t_data;
    tclk_run = 1; dpos = 1; dneg = 0;
    wait_cyc(20);
    chk(pos == 1 && neg == 0, "R7 data 10", {pos, neg}, 2);
    chk(src == 0, "R4 src tclk", src, 0);
    dpos = 0; dneg = 1;
    wait_cyc(20);
    chk(pos == 0 && neg == 1, "R7 data 01", {pos, neg}, 1);
  endtask

  task automatic t_hiz;
    hiz = 1; wait_cyc(2);
    chk(drv_en == 0, "R3 hiz", drv_en, 0);
    hiz = 0; wait_cyc(2);
    chk(drv_en == 1, "R3 release", drv_en, 1);
  endtask

  task automatic t_loss;
    tclk_run = 0;
    wait_cyc(690);
    chk(drv_en == 1, "R1 not early", drv_en, 1);
    wait_cyc(20);
    chk(drv_en == 0, "R1 lost", drv_en, 0);
    chk(src == 2, "R4 src ref", src, 2);
    tclk_run = 1;
    wait_cyc(10);
    chk(drv_en == 1, "R2 recover", drv_en, 1);
    chk(src == 0, "R2 src back", src, 0);
  endtask

  task automatic t_aos;
    int tog, bad;
    tclk_run = 0; wait_cyc(720);
    aos = 1; dpos = 1; dneg = 1;
    wait_cyc(4);
    chk(src == 2, "R4 ref fallback", src, 2);
    chk(drv_en == 1, "R6 drive kept", drv_en, 1);
    count_marks(40, tog, bad);
    chk(bad == 0, "R5 one rail ref", bad, 0);
    chk(tog >= 9 && tog <= 11, "R5 ref rate", tog, 10);
    mclk_run = 1; wait_cyc(20);
    chk(src == 1, "R4 mclk fallback", src, 1);
    count_marks(80, tog, bad);
    chk(bad == 0, "R5 one rail mclk", bad, 0);
    chk(tog >= 9 && tog <= 11, "R5 mclk rate", tog, 10);
    tclk_run = 1; wait_cyc(20);
    chk(src == 0, "R4 tclk priority", src, 0);
    count_marks(40, tog, bad);
    chk(bad == 0, "R5 one rail tclk", bad, 0);
    chk(tog >= 9 && tog <= 11, "R5 tclk rate", tog, 10);
    mclk_run = 0; aos = 0; dpos = 0; dneg = 0;
    wait_cyc(20);
  endtask

  task automatic t_rloop;
    wait_cyc(120);
    rloop = 1; wait_cyc(4);
    aos = 1; dpos = 0; dneg = 1;
    wait_cyc(3);
    chk(settling == 0, "R10 no settle", settling, 0);
    wait_cyc(17);
    chk(pos == 0 && neg == 1, "R8 data 01", {pos, neg}, 1);
    dpos = 1; dneg = 0; wait_cyc(20);
    chk(pos == 1 && neg == 0, "R8 data 10", {pos, neg}, 2);
    aos = 0; wait_cyc(4);
    rloop = 0; dpos = 0; dneg = 0;
  endtask

  task automatic t_settle;
    wait_cyc(120);
    chk(settling == 0, "R9 idle", settling, 0);
    ctrl = 6'b000001; wait_cyc(2);
    chk(settling == 1, "R9 start", settling, 1);
    wait_cyc(70);
    chk(settling == 1, "R9 held", settling, 1);
    wait_cyc(40);
    chk(settling == 0, "R9 expired", settling, 0);
    aos = 1; wait_cyc(2);
    chk(settling == 1, "R9 aos toggle", settling, 1);
    aos = 0;
  endtask

  bit done = 0;
  initial begin
    wait_cyc(2);
    t_reset();
    rst_n = 1;
    t_data();
    t_hiz();
    t_loss();
    t_aos();
    t_rloop();
    t_settle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        wait_cyc(100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule